// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block sits in a memory controller and decides, one row at a time, whether a DRAM row must be refreshed in the current refresh window. Rows whose weakest cell leaks quickly are recorded in one of two retention bins. Each bin is a Bloom filter addressed by hashes of the row address. A row that is in no bin is refreshed at a slow default rate.

A `tick` pulse marks each base interval (64 ms in the target system, shorter in simulation) and starts an epoch. A 2-bit epoch counter cycles through four epochs. In every epoch a row counter sweeps all row addresses in ascending order and probes both filters. A row in the fast bin is due in every epoch. A row in the middle bin is due in every second epoch. A row in neither bin is due once in four epochs. Each due row is offered on a valid/ready refresh output together with its class. The sweep holds on a row while its request is waiting. Software loads the filters through an insert pin and empties them with a clear pin.

Back-pressure rules: once `rf_valid` rises, `rf_row` and `rf_bin` stay constant and `rf_valid` stays high until a cycle in which `rf_ready` is high. That cycle completes the transfer. The sweep does not move on while a request is pending. Rows that are not due take one cycle each. Rows that are due take at least two cycles.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset `rf_valid` is low, both filters are empty and no request is issued until the first `tick`. The first `tick` after reset starts epoch 0.
- R2: A row inserted with `ins_bin`=0 is reported with class code 0 on `rf_bin` and is requested in every epoch. An insert is visible to probes from the next cycle on.
- R3: A row inserted with `ins_bin`=1 only is reported with class code 1 and is requested only in epochs 0 and 2 (epoch bit 0 clear).
- R4: A row in no bin is reported with class code 2 and is requested only in epoch 0. Epoch 0 is the first epoch after reset and then every fourth epoch.
- R5: A row present in both filters is treated as bin 0 (class code 0, due every epoch).
- R6: Within one epoch the sweep visits every row address exactly once in ascending order. Each due row produces exactly one transfer.
- R7: While `rf_valid` is high and `rf_ready` is low, `rf_valid`, `rf_row` and `rf_bin` hold their values and no further row is offered.
- R8: A `tick` that arrives while a sweep is still running is remembered. The next epoch starts as soon as that sweep completes, so no epoch is lost.
- R9: `flt_clear` empties both filters, and every row reverts to class code 2. When `flt_clear` and `ins_en` are high in the same cycle, the clear wins and the insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse marking the base refresh interval |
| flt_clear | input | 1 | Empties both Bloom filters |
| ins_en | input | 1 | Inserts `ins_row` into the filter chosen by `ins_bin` |
| ins_bin | input | 1 | Target filter: 0 = fast bin, 1 = middle bin |
| ins_row | input | ROW_W | Row address to insert |
| rf_valid | output | 1 | A refresh request is offered |
| rf_ready | input | 1 | Consumer accepts the request in this cycle |
| rf_row | output | ROW_W | Row address to refresh |
| rf_bin | output | 2 | Class of the requested row: 0 fast, 1 middle, 2 default |

## Verification
Two kinds of event can land in the same cycle. The first pair is a filter clear and an insert: the bench raises both together and then runs several epochs. The dropped row must appear only with the default class, and rows inserted earlier must be gone. The second pair is a new `tick` and a sweep that is still running: the bench sends a second tick a few cycles into an epoch. The bench then counts each row's transfers and checks that both epochs completed in full, with the right per-row counts. A held refresh request under back-pressure also overlaps with the sweep. This case is judged by checking that the row and class stay frozen and that no transfer is counted while ready is low.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    CLS_FAST = 2'd0,
    CLS_MID  = 2'd1,
    CLS_SLOW = 2'd2
  } rr_cls_e;

  // Row hash: rotate the row left by the hash number, XOR-fold it to the
  // index width, then salt the top nibble with the hash number plus one.
  function automatic logic [31:0] rr_hash(input logic [63:0] row,
                                          input int unsigned row_w,
                                          input int unsigned idx_w,
                                          input int unsigned hnum);
    logic [63:0] rot;
    logic [63:0] acc;
    logic [63:0] mask;
    rot = '0;
    acc = '0;
    for (int j = 0; j < 64; j++) begin
      if (j < row_w) rot[6'((j + hnum) % row_w)] = row[j];
    end
    for (int j = 0; j < 64; j++) begin
      if (j < row_w) acc[6'(j % idx_w)] = acc[6'(j % idx_w)] ^ rot[j];
    end
    acc = acc ^ (64'(hnum + 1) << (idx_w - 4));
    mask = (64'd1 << idx_w) - 64'd1;
    return 32'(acc & mask);
  endfunction

endpackage

// File: rtl/rr_bloom_bank.sv
module rr_bloom_bank
  import rr_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int BITS  = 2048,
  parameter int K     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [ROW_W-1:0] prb_row,
  output logic             hit
);
  localparam int IDX_W  = $clog2(BITS);
  localparam int WORD_W = 64;
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int DEPTH  = BITS / WORD_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  ins_idx [K];
  logic [IDX_W-1:0]  prb_idx [K];

  for (genvar g = 0; g < K; g++) begin : g_hash
    assign ins_idx[g] = IDX_W'(rr_hash(64'(ins_row), ROW_W, IDX_W, g));
    assign prb_idx[g] = IDX_W'(rr_hash(64'(prb_row), ROW_W, IDX_W, g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (ins) begin
      for (int i = 0; i < K; i++)
        mem[ins_idx[i][IDX_W-1:BSEL_W]][ins_idx[i][BSEL_W-1:0]] <= 1'b1;
    end
  end

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < K; i++)
      hit = hit & mem[prb_idx[i][IDX_W-1:BSEL_W]][prb_idx[i][BSEL_W-1:0]];
  end

  AST_INS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ins && !clr) && prb_row == $past(ins_row)) |-> hit); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit); // R9

endmodule

// File: rtl/rr_due_select.sv
module rr_due_select
  import rr_pkg::*;
#(
  parameter int EPOCH_W = 2
) (
  input  logic               hit_fast,
  input  logic               hit_mid,
  input  logic [EPOCH_W-1:0] epoch,
  output rr_cls_e            cls,
  output logic               due
);
  always_comb begin
    if (hit_fast) begin
      cls = CLS_FAST;
      due = 1'b1;
    end else if (hit_mid) begin
      cls = CLS_MID;
      due = ~epoch[0];
    end else begin
      cls = CLS_SLOW;
      due = (epoch == '0);
    end
  end
endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import rr_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int B0_BITS = 2048,
  parameter int B0_K    = 10,
  parameter int B1_BITS = 8192,
  parameter int B1_K    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             flt_clear,
  input  logic             ins_en,
  input  logic             ins_bin,
  input  logic [ROW_W-1:0] ins_row,
  output logic             rf_valid,
  input  logic             rf_ready,
  output logic [ROW_W-1:0] rf_row,
  output logic [1:0]       rf_bin
);
  localparam int NBIN    = 2;
  localparam int EPOCH_W = 2;
  localparam int BITS_A [NBIN] = '{B0_BITS, B1_BITS};
  localparam int K_A    [NBIN] = '{B0_K, B1_K};

  logic               busy, tick_pend, due, adv, last_row;
  logic [ROW_W-1:0]   rowc;
  logic [EPOCH_W-1:0] epoch;
  logic [NBIN-1:0]    hit;
  rr_cls_e            cls;

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    rr_bloom_bank #(.ROW_W(ROW_W), .BITS(BITS_A[b]), .K(K_A[b])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flt_clear),
      .ins     (ins_en && (ins_bin == 1'(b))),
      .ins_row (ins_row),
      .prb_row (rowc),
      .hit     (hit[b])
    );
  end

  rr_due_select #(.EPOCH_W(EPOCH_W)) u_due (
    .hit_fast (hit[0]),
    .hit_mid  (hit[1]),
    .epoch    (epoch),
    .cls      (cls),
    .due      (due)
  );

  assign last_row = (rowc == '1);
  assign adv      = busy && (rf_valid ? rf_ready : !due);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tick_pend <= 1'b0;
      rowc      <= '0;
      epoch     <= '1;
      rf_valid  <= 1'b0;
      rf_row    <= '0;
      rf_bin    <= CLS_SLOW;
    end else if (!busy) begin
      if (tick || tick_pend) begin
        busy      <= 1'b1;
        tick_pend <= 1'b0;
        rowc      <= '0;
        epoch     <= epoch + 1'b1;
      end
    end else begin
      if (tick) tick_pend <= 1'b1;
      if (rf_valid) begin
        if (rf_ready) rf_valid <= 1'b0;
      end else if (due) begin
        rf_valid <= 1'b1;
        rf_row   <= rowc;
        rf_bin   <= cls;
      end
      if (adv) begin
        if (last_row) busy <= 1'b0;
        else          rowc <= rowc + 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rf_valid); // R1
  AST_MID_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && rf_bin == CLS_MID) |-> !epoch[0]); // R3
  AST_SLOW_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && rf_bin == CLS_SLOW) |-> (epoch == '0)); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rowc == $past(rowc) || rowc == $past(rowc) + 1'b1)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_ready) |=> (rf_valid && $stable(rf_row) && $stable(rf_bin))); // R7

endmodule

// File: tb/sim_retention_refresh_sched.sv
`timescale 1ns/1ps
module sim_retention_refresh_sched;
  localparam int ROW_W = 6;
  localparam int NROWS = 1 << ROW_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             flt_clear = 1'b0;
  logic             ins_en = 1'b0;
  logic             ins_bin = 1'b0;
  logic [ROW_W-1:0] ins_row = '0;
  logic             rf_valid;
  logic             rf_ready = 1'b1;
  logic [ROW_W-1:0] rf_row;
  logic [1:0]       rf_bin;

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;   // 0 always ready, 1 toggling, 2 held low
  bit done = 0;

  int cnt [NROWS];
  int cls_seen [NROWS];
  int nreq, order_err, last_row;
  bit have_last;

  always #10 clk = ~clk;

  retention_refresh_sched #(.ROW_W(ROW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flt_clear(flt_clear),
    .ins_en(ins_en), .ins_bin(ins_bin), .ins_row(ins_row),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_row(rf_row), .rf_bin(rf_bin)
  );

  // Transfer monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && rf_valid && rf_ready) begin
      cnt[rf_row] = cnt[rf_row] + 1;
      cls_seen[rf_row] = int'(rf_bin);
      if (have_last && int'(rf_row) <= last_row) order_err = order_err + 1;
      last_row = int'(rf_row);
      have_last = 1;
      nreq = nreq + 1;
    end
  end

  // Ready driver.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: rf_ready = 1'b1;
        1: rf_ready = ~rf_ready;
        default: rf_ready = 1'b0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic clear_log();
    for (int i = 0; i < NROWS; i++) begin
      cnt[i] = 0;
      cls_seen[i] = -1;
    end
    nreq = 0;
    order_err = 0;
    have_last = 0;
    last_row = -1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick();
    @(posedge clk); #1;
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic insert(input bit bin, input int row);
    @(posedge clk); #1;
    ins_en = 1'b1; ins_bin = bin; ins_row = ROW_W'(row);
    @(posedge clk); #1;
    ins_en = 1'b0;
  endtask

  task automatic run_epoch();
    clear_log();
    pulse_tick();
    cycles(400);
  endtask

  int off_cnt;
  task automatic count_not_once();
    off_cnt = 0;
    for (int i = 0; i < NROWS; i++) if (cnt[i] != 1) off_cnt++;
  endtask

  task automatic t_reset();
    cycles(3);
    rst_n = 1'b1;
    clear_log();
    @(negedge clk);
    chk(rf_valid == 1'b0, "R1 valid low after reset", int'(rf_valid), 0);
    cycles(60);
    chk(nreq == 0, "R1 no request before first tick", nreq, 0);
  endtask

  task automatic t_program();
    insert(1'b0, 5);
    insert(1'b1, 9);
    insert(1'b0, 12);
    insert(1'b1, 12);
  endtask

  // Epoch 0 under toggling ready: full sweep, every class seen.
  task automatic t_epoch0_stalled();
    ready_mode = 1;
    run_epoch();
    ready_mode = 0;
    count_not_once();
    chk(nreq == NROWS, "R6 one transfer per row in epoch 0", nreq, NROWS);
    chk(off_cnt == 0, "R6 rows not visited exactly once", off_cnt, 0);
    chk(order_err == 0, "R6 ascending order", order_err, 0);
    chk(cls_seen[5] == 0, "R2 fast row class", cls_seen[5], 0);
    chk(cls_seen[9] == 1, "R3 middle row class", cls_seen[9], 1);
    chk(cls_seen[12] == 0, "R5 dual row takes fast class", cls_seen[12], 0);
    chk(cls_seen[40] == 2, "R4 default row class", cls_seen[40], 2);
  endtask

  // Epoch 1 with ready held low, then released.
  task automatic t_epoch1_backpressure();
    int waitc;
    ready_mode = 2;
    clear_log();
    pulse_tick();
    waitc = 0;
    while (!rf_valid && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    chk(rf_valid && rf_row == 5, "R7 first due row offered", int'(rf_row), 5);
    cycles(6);
    @(negedge clk);
    chk(rf_valid == 1'b1, "R7 valid held under back-pressure", int'(rf_valid), 1);
    chk(rf_row == 5 && rf_bin == 2'd0, "R7 row stable under back-pressure", int'(rf_row), 5);
    chk(nreq == 0, "R7 no transfer while ready low", nreq, 0);
    ready_mode = 0;
    cycles(400);
    chk(nreq == 2, "R2 only fast rows in epoch 1", nreq, 2);
    chk(cnt[5] == 1 && cnt[12] == 1, "R2 fast rows refreshed in epoch 1", cnt[5] + cnt[12], 2);
    chk(cnt[9] == 0, "R3 middle row skipped in epoch 1", cnt[9], 0);
    chk(cnt[0] == 0, "R4 default row skipped in epoch 1", cnt[0], 0);
  endtask

  // Epochs 2 and 3: second tick lands while the first sweep runs.
  task automatic t_tick_during_sweep();
    clear_log();
    pulse_tick();
    cycles(5);
    pulse_tick();
    cycles(700);
    chk(cnt[5] == 2, "R8 fast row in both epochs", cnt[5], 2);
    chk(cnt[12] == 2, "R8 dual row in both epochs", cnt[12], 2);
    chk(cnt[9] == 1, "R3 middle row once over epochs 2 and 3", cnt[9], 1);
    chk(nreq == 5, "R8 total transfers over two epochs", nreq, 5);
  endtask

  task automatic t_wrap();
    run_epoch();
    chk(nreq == NROWS, "R4 epoch counter wraps to epoch 0", nreq, NROWS);
    chk(cls_seen[63] == 2, "R4 last row default class", cls_seen[63], 2);
  endtask

  // Clear and insert in the same cycle, then normal insert afterwards.
  task automatic t_clear_collision();
    @(posedge clk); #1;
    flt_clear = 1'b1; ins_en = 1'b1; ins_bin = 1'b0; ins_row = ROW_W'(20);
    @(posedge clk); #1;
    flt_clear = 1'b0; ins_en = 1'b0;
    insert(1'b1, 33);
    run_epoch();  // epoch 1
    chk(nreq == 0, "R9 cleared and dropped rows absent in epoch 1", nreq, 0);
    run_epoch();  // epoch 2
    chk(nreq == 1 && cnt[33] == 1, "R9 insert after clear visible", nreq, 1);
    chk(cls_seen[33] == 1, "R3 re-inserted middle row class", cls_seen[33], 1);
    run_epoch();  // epoch 3
    chk(nreq == 0, "R3 nothing due in epoch 3", nreq, 0);
    run_epoch();  // epoch 0
    chk(nreq == NROWS, "R4 full sweep in epoch 0", nreq, NROWS);
    chk(cls_seen[5] == 2, "R9 cleared row back to default", cls_seen[5], 2);
    chk(cls_seen[20] == 2, "R9 clear wins over same-cycle insert", cls_seen[20], 2);
  endtask

  initial begin
    clear_log();
    t_reset();
    t_program();
    t_epoch0_stalled();
    t_epoch1_backpressure();
    t_tick_during_sweep();
    t_wrap();
    t_clear_collision();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule